// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block keeps the first status byte of a serial NOR flash device and enforces the rules for changing it. Commands arrive already decoded as single-cycle strobes: latch-set, latch-clear, error-clear, register write (carrying a data byte) and status read. An active-low write-protect pin and an array sequencer's events (operation start with its kind, operation done, failure, protected-target hit) complete the input side. The block drives the eight status bits and a one-cycle pulse when a register write is accepted.

The control is a three-state machine. `ST_IDLE` accepts commands. It moves to `ST_REG_WRITE` on an accepted register write and returns to `ST_IDLE` after `WRR_CYCLES` busy cycles, when the new lock and protect bits take effect. It moves to `ST_ARRAY_OP` on an accepted array operation and returns to `ST_IDLE` on `op_done`. The lock bit and the three protect bits live in retained storage that only the power-on load clears. The ordinary reset leaves them as they are, except that it forces the protect bits high when they are configured as volatile.

Top module: `flash_status_ctl`

## Requirements
- R1: `status` bit 7 is the write lock, bit 6 the program error, bit 5 the erase error, bits 4..2 the protect field, bit 1 the write-enable latch and bit 0 busy.
- R2: In `ST_IDLE`, `cmd_wren` sets the latch and `cmd_wrdi` clears it. The data byte of a register write never sets the latch.
- R3: A register write strobed while the latch is 0 is dropped. `wrr_ok` stays 0 and no status bit changes.
- R4: A register write strobed while the lock bit is 1 and `wp_n` is 0 is dropped. Otherwise an accepted write copies data bits 7 and 4..2 into the lock and protect bits, and the other four bits of the byte are not stored.
- R5: An accepted register write drives `wrr_ok` high in the next cycle. Busy then reads 1 for `WRR_CYCLES` cycles with the old contents, and the new contents appear when busy falls.
- R6: `op_start` with kind 0 (program), 1 (sector erase) or 2 (bulk erase) is ignored while the latch is 0. Kind 3 (other) is accepted regardless, and an accepted start makes busy 1 until `op_done`.
- R7: The program error bit sets when a program operation completes with `op_fail` or `op_prot` high.
- R8: The erase error bit sets when a sector erase completes with `op_fail` or `op_prot` high, or when a bulk erase completes with `op_fail` high. A bulk erase with only `op_prot` high leaves it unchanged.
- R9: `cmd_clsr` clears both error bits in any state, but a completion that sets an error bit in the same cycle wins. A register write never changes the error bits.
- R10: While busy is 1, `cmd_wren`, `cmd_wrdi`, `cmd_wrr` and `op_start` have no effect.
- R11: The latch clears when an accepted register write, program or erase completes. Completion of a kind-3 operation leaves it unchanged.
- R12: With `rst_n` low, busy, the latch, `wrr_ok` and both error bits go to 0 and the lock bit holds its value. The protect field becomes 3'b111 if `cfg_bp_volatile` is 1 and holds its value otherwise.
- R13: `por_load` clears every status bit, including the lock bit and the protect field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the volatile state |
| por_load | input | 1 | Power-on load: clears all bits, including the retained ones |
| cfg_bp_volatile | input | 1 | Protect field is volatile and resets to all ones |
| wp_n | input | 1 | Active-low write-protect pin |
| cmd_wren | input | 1 | Set write-enable latch strobe |
| cmd_wrdi | input | 1 | Clear write-enable latch strobe |
| cmd_clsr | input | 1 | Clear error bits strobe |
| cmd_rdsr | input | 1 | Status read strobe (no state effect) |
| cmd_wrr | input | 1 | Register write strobe |
| wrr_data | input | 8 | Register write data byte |
| op_start | input | 1 | Array operation start strobe |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 bulk erase, 3 other |
| op_done | input | 1 | Array operation completion strobe |
| op_fail | input | 1 | Operation failed, sampled with `op_done` |
| op_prot | input | 1 | Operation hit a protected target, sampled with `op_done` |
| status | output | 8 | Status register value |
| wrr_ok | output | 1 | One-cycle pulse after an accepted register write |

## Verification
The hardest state to reach is the hardware-protected refusal. It needs the lock bit already committed to 1 by an earlier accepted write, the latch set again, and the pin low at the moment of the write strobe. A pin toggle during the busy window must not matter. Directed steps build this chain explicitly. The random phase then sets the write strobe and latch-set probabilities high enough that the lock bit is committed often, while the pin changes randomly across strobes and reset pulses with a random volatile setting reshuffle the protect field.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_REG_WRITE = 2'd1,
        ST_ARRAY_OP  = 2'd2
    } fsr_state_e;

    typedef enum logic [1:0] {
        OP_PROGRAM      = 2'd0,
        OP_SECTOR_ERASE = 2'd1,
        OP_BULK_ERASE   = 2'd2,
        OP_OTHER        = 2'd3
    } fsr_op_e;

    localparam int BIT_LOCK  = 7;
    localparam int BIT_PERR  = 6;
    localparam int BIT_EERR  = 5;
    localparam int BP_HI     = 4;
    localparam int BP_LO     = 2;
    localparam int BIT_WEL   = 1;
    localparam int BIT_BUSY  = 0;
    localparam int BP_W      = BP_HI - BP_LO + 1;
endpackage

// File: rtl/fsr_fsm.sv
module fsr_fsm
    import fsr_pkg::*;
#(
    parameter int WRR_CYCLES = 4
) (
    input  logic       clk,
    input  logic       srst,
    input  logic       cmd_wren,
    input  logic       cmd_wrdi,
    input  logic       cmd_wrr,
    input  logic [7:0] wrr_data,
    input  logic       lock,
    input  logic       op_start,
    input  fsr_op_e    op_kind,
    input  logic       op_done,
    output logic       busy,
    output logic       wel,
    output logic       wrr_ok,
    output logic       wrr_commit,
    output logic       arr_done,
    output fsr_op_e    arr_kind,
    output logic [7:0] wrr_value
);
    localparam int CW = (WRR_CYCLES > 1) ? $clog2(WRR_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(WRR_CYCLES - 1);

    fsr_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [7:0]    data_q;
    fsr_op_e       kind_q;
    logic          wel_q, ok_q;
    logic          wrr_take, op_take, in_idle;

    assign in_idle  = (state_q == ST_IDLE);
    assign wrr_take = in_idle && cmd_wrr && wel_q && !lock;
    assign op_take  = in_idle && !wrr_take && op_start
                      && (op_kind == OP_OTHER || wel_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wrr_take)     state_d = ST_REG_WRITE;
                else if (op_take) state_d = ST_ARRAY_OP;
            end
            ST_REG_WRITE: if (cnt_q == CNT_LAST) state_d = ST_IDLE;
            ST_ARRAY_OP:  if (op_done) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            data_q  <= '0;
            kind_q  <= OP_OTHER;
        end else begin
            state_q <= state_d;
            cnt_q   <= in_idle ? '0 : cnt_q + 1'b1;
            if (wrr_take) data_q <= wrr_data;
            if (op_take)  kind_q <= op_kind;
        end
    end

    always_comb begin
        busy       = !in_idle;
        wrr_commit = (state_q == ST_REG_WRITE) && (cnt_q == CNT_LAST);
        arr_done   = (state_q == ST_ARRAY_OP) && op_done;
        arr_kind   = kind_q;
        wrr_value  = data_q;
        wel        = wel_q;
        wrr_ok     = ok_q;
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            wel_q <= 1'b0;
            ok_q  <= 1'b0;
        end else begin
            ok_q <= wrr_take;
            if (wrr_commit || (arr_done && kind_q != OP_OTHER)) wel_q <= 1'b0;
            else if (in_idle && cmd_wrdi)                       wel_q <= 1'b0;
            else if (in_idle && cmd_wren)                       wel_q <= 1'b1;
        end
    end

    p_wel_rise_r2: assert property (@(posedge clk) disable iff (srst)
        $rose(wel_q) |-> $past(cmd_wren));
    p_lock_drop_r4: assert property (@(posedge clk) disable iff (srst)
        (in_idle && cmd_wrr && lock) |=> !ok_q);
    p_drop_no_latch_r3: assert property (@(posedge clk) disable iff (srst)
        (in_idle && cmd_wrr && !wel_q) |=> !ok_q);
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (srst)
        (!in_idle && !wrr_commit && !arr_done) |=> $stable(wel_q));
    p_accept_busy_r5: assert property (@(posedge clk) disable iff (srst)
        ok_q |-> busy);
endmodule

// File: rtl/fsr_errbits.sv
module fsr_errbits
    import fsr_pkg::*;
(
    input  logic    clk,
    input  logic    srst,
    input  logic    cmd_clsr,
    input  logic    arr_done,
    input  fsr_op_e arr_kind,
    input  logic    op_fail,
    input  logic    op_prot,
    output logic    perr,
    output logic    eerr
);
    logic perr_q, eerr_q, prog_bad, erase_bad;

    assign prog_bad  = arr_done && (arr_kind == OP_PROGRAM) && (op_fail || op_prot);
    assign erase_bad = arr_done && (((arr_kind == OP_SECTOR_ERASE) && (op_fail || op_prot))
                                 || ((arr_kind == OP_BULK_ERASE) && op_fail));

    always_ff @(posedge clk) begin
        if (srst) begin
            perr_q <= 1'b0;
            eerr_q <= 1'b0;
        end else begin
            if (prog_bad)      perr_q <= 1'b1;
            else if (cmd_clsr) perr_q <= 1'b0;
            if (erase_bad)     eerr_q <= 1'b1;
            else if (cmd_clsr) eerr_q <= 1'b0;
        end
    end

    assign perr = perr_q;
    assign eerr = eerr_q;

    p_bulk_prot_r8: assert property (@(posedge clk) disable iff (srst)
        (arr_done && arr_kind == OP_BULK_ERASE && !op_fail && !eerr_q) |=> !eerr_q);
    p_clear_r9: assert property (@(posedge clk) disable iff (srst)
        (cmd_clsr && !arr_done) |=> (!perr_q && !eerr_q));
    p_perr_cause_r7: assert property (@(posedge clk) disable iff (srst)
        $rose(perr_q) |-> $past(arr_done && arr_kind == OP_PROGRAM));
endmodule

// File: rtl/fsr_nvbits.sv
module fsr_nvbits
    import fsr_pkg::*;
(
    input  logic            clk,
    input  logic            por_load,
    input  logic            rst_n,
    input  logic            cfg_bp_volatile,
    input  logic            wrr_commit,
    input  logic [7:0]      wr_val,
    output logic            lock_bit,
    output logic [BP_W-1:0] bp
);
    localparam logic [BP_W-1:0] BP_ONES = '1;

    logic            lock_q;
    logic [BP_W-1:0] bp_q;
    logic            unused_wr_bits;

    assign unused_wr_bits = ^{wr_val[BIT_PERR], wr_val[BIT_EERR], wr_val[BIT_WEL], wr_val[BIT_BUSY]};

    always_ff @(posedge clk) begin
        if (por_load) begin
            lock_q <= 1'b0;
            bp_q   <= '0;
        end else if (!rst_n) begin
            if (cfg_bp_volatile) bp_q <= BP_ONES;
        end else if (wrr_commit) begin
            lock_q <= wr_val[BIT_LOCK];
            bp_q   <= wr_val[BP_HI:BP_LO];
        end
    end

    assign lock_bit = lock_q;
    assign bp       = bp_q;

    p_nv_hold_r4: assert property (@(posedge clk) disable iff (por_load)
        (rst_n && !wrr_commit) |=> $stable({lock_q, bp_q}));
    p_vol_reset_r12: assert property (@(posedge clk) disable iff (por_load)
        (!rst_n && cfg_bp_volatile) |=> (bp_q == BP_ONES));
    p_lock_keep_r12: assert property (@(posedge clk) disable iff (por_load)
        (!rst_n) |=> $stable(lock_q));
endmodule

// File: rtl/flash_status_ctl.sv
module flash_status_ctl
    import fsr_pkg::*;
#(
    parameter int WRR_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_load,
    input  logic       cfg_bp_volatile,
    input  logic       wp_n,
    input  logic       cmd_wren,
    input  logic       cmd_wrdi,
    input  logic       cmd_clsr,
    input  logic       cmd_rdsr,
    input  logic       cmd_wrr,
    input  logic [7:0] wrr_data,
    input  logic       op_start,
    input  logic [1:0] op_kind,
    input  logic       op_done,
    input  logic       op_fail,
    input  logic       op_prot,
    output logic [7:0] status,
    output logic       wrr_ok
);
    logic            srst, busy, wel, commit, arr_done, perr, eerr, lock_bit, hw_lock;
    logic            unused_rdsr;
    logic [7:0]      wr_val;
    logic [BP_W-1:0] bp;
    fsr_op_e         arr_kind;

    assign srst        = por_load || !rst_n;
    assign hw_lock     = lock_bit && !wp_n;
    assign unused_rdsr = cmd_rdsr;

    fsr_fsm #(.WRR_CYCLES(WRR_CYCLES)) u_fsm (
        .clk        (clk),
        .srst       (srst),
        .cmd_wren   (cmd_wren),
        .cmd_wrdi   (cmd_wrdi),
        .cmd_wrr    (cmd_wrr),
        .wrr_data   (wrr_data),
        .lock       (hw_lock),
        .op_start   (op_start),
        .op_kind    (fsr_op_e'(op_kind)),
        .op_done    (op_done),
        .busy       (busy),
        .wel        (wel),
        .wrr_ok     (wrr_ok),
        .wrr_commit (commit),
        .arr_done   (arr_done),
        .arr_kind   (arr_kind),
        .wrr_value  (wr_val)
    );

    fsr_errbits u_err (
        .clk      (clk),
        .srst     (srst),
        .cmd_clsr (cmd_clsr),
        .arr_done (arr_done),
        .arr_kind (arr_kind),
        .op_fail  (op_fail),
        .op_prot  (op_prot),
        .perr     (perr),
        .eerr     (eerr)
    );

    fsr_nvbits u_nv (
        .clk             (clk),
        .por_load        (por_load),
        .rst_n           (rst_n),
        .cfg_bp_volatile (cfg_bp_volatile),
        .wrr_commit      (commit),
        .wr_val          (wr_val),
        .lock_bit        (lock_bit),
        .bp              (bp)
    );

    always_comb begin
        status                = '0;
        status[BIT_LOCK]      = lock_bit;
        status[BIT_PERR]      = perr;
        status[BIT_EERR]      = eerr;
        status[BP_HI:BP_LO]   = bp;
        status[BIT_WEL]       = wel;
        status[BIT_BUSY]      = busy;
    end

    p_busy_idle_r6: assert property (@(posedge clk) disable iff (srst)
        (!busy && op_start && op_kind != 2'd3 && !wel && !cmd_wrr) |=> !busy);
endmodule

// File: tb/sim_flash_status_ctl.sv
`timescale 1ns/1ps
module sim_flash_status_ctl;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0, por_load = 1'b1, cfg_bp_volatile = 1'b0, wp_n = 1'b1;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_clsr = 0, cmd_rdsr = 0, cmd_wrr = 0;
    logic [7:0] wrr_data = '0;
    logic op_start = 0, op_done = 0, op_fail = 0, op_prot = 0;
    logic [1:0] op_kind = '0;
    logic [7:0] status;
    logic wrr_ok;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flash_status_ctl #(.WRR_CYCLES(W)) u0 (
        .clk(clk), .rst_n(rst_n), .por_load(por_load), .cfg_bp_volatile(cfg_bp_volatile),
        .wp_n(wp_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_clsr(cmd_clsr),
        .cmd_rdsr(cmd_rdsr), .cmd_wrr(cmd_wrr), .wrr_data(wrr_data), .op_start(op_start),
        .op_kind(op_kind), .op_done(op_done), .op_fail(op_fail), .op_prot(op_prot),
        .status(status), .wrr_ok(wrr_ok)
    );

    // reference model of the requirements
    bit m_lock, m_perr, m_eerr, m_wel, m_ok;
    bit [2:0] m_bp;
    int m_st = 0, m_cnt = 0;
    bit [7:0] m_data;
    int m_kind = 3;

    function automatic bit [7:0] model_status();
        return {m_lock, m_perr, m_eerr, m_bp, m_wel, (m_st != 0)};
    endfunction

    function automatic bit prog_err(int k, bit f, bit p);
        return (k == 0) && (f || p);
    endfunction

    function automatic bit erase_err(int k, bit f, bit p);
        return ((k == 1) && (f || p)) || ((k == 2) && f);
    endfunction

    always @(posedge clk) begin
        bit commit, done, take_w, take_o;
        commit = (m_st == 1) && (m_cnt == W - 1);
        done   = (m_st == 2) && op_done;
        take_w = (m_st == 0) && cmd_wrr && m_wel && !(m_lock && !wp_n);
        take_o = (m_st == 0) && !take_w && op_start && (op_kind == 2'd3 || m_wel);
        if (por_load) begin
            m_lock = 0; m_bp = 0;
        end else if (!rst_n) begin
            if (cfg_bp_volatile) m_bp = 3'b111;
        end else if (commit) begin
            m_lock = m_data[7]; m_bp = m_data[4:2];
        end
        if (por_load || !rst_n) begin
            m_perr = 0; m_eerr = 0; m_wel = 0; m_ok = 0; m_st = 0; m_cnt = 0;
        end else begin
            if (done && prog_err(m_kind, op_fail, op_prot)) m_perr = 1;
            else if (cmd_clsr) m_perr = 0;
            if (done && erase_err(m_kind, op_fail, op_prot)) m_eerr = 1;
            else if (cmd_clsr) m_eerr = 0;
            if (commit || (done && m_kind != 3)) m_wel = 0;
            else if (m_st == 0 && cmd_wrdi) m_wel = 0;
            else if (m_st == 0 && cmd_wren) m_wel = 1;
            m_ok = take_w;
            if (m_st == 0) begin
                m_cnt = 0;
                if (take_w) begin m_st = 1; m_data = wrr_data; end
                else if (take_o) begin m_st = 2; m_kind = int'(op_kind); end
            end else if (m_st == 1) begin
                if (commit) m_st = 0;
                m_cnt = m_cnt + 1;
            end else begin
                if (op_done) m_st = 0;
                m_cnt = m_cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic tick();
        bit [7:0] ms;
        @(posedge clk);
        @(negedge clk);
        ms = model_status();
        chk("R4 lock/protect", {status[7], status[4:2]}, {ms[7], ms[4:2]});
        chk("R7 program error", status[6], ms[6]);
        chk("R8 erase error", status[5], ms[5]);
        chk("R2 latch", status[1], ms[1]);
        chk("R5 busy", status[0], ms[0]);
        chk("R3 wrr_ok", wrr_ok, m_ok);
        cmd_wren = 0; cmd_wrdi = 0; cmd_clsr = 0; cmd_rdsr = 0; cmd_wrr = 0;
        op_start = 0; op_done = 0; op_fail = 0; op_prot = 0;
    endtask

    task automatic wren();  cmd_wren = 1; tick(); endtask
    task automatic wrdi();  cmd_wrdi = 1; tick(); endtask
    task automatic clsr();  cmd_clsr = 1; tick(); endtask
    task automatic wrr(input logic [7:0] d); cmd_wrr = 1; wrr_data = d; tick(); endtask
    task automatic start(input logic [1:0] k); op_start = 1; op_kind = k; tick(); endtask
    task automatic done(input logic f, input logic p); op_done = 1; op_fail = f; op_prot = p; tick(); endtask
    task automatic wait_write(); repeat (W) tick(); endtask
    task automatic pulse_rst(input logic vol);
        rst_n = 0; cfg_bp_volatile = vol; tick(); rst_n = 1;
    endtask

    initial begin
        #(150000 * 5);
        errors++; checks++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        finished = 1;
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        tick(); tick();
        por_load = 0; rst_n = 1;
        tick();
        chk("R13 power-on value", status, 8'h00);
        chk("R12 reset wrr_ok", wrr_ok, 1'b0);

        wren();
        chk("R2 latch set", status, 8'h02);
        chk("R1 latch at bit 1", status[1], 1'b1);
        wrr(8'h9C);
        chk("R5 accept pulse", wrr_ok, 1'b1);
        chk("R5 old contents while busy", status, 8'h03);
        repeat (W - 1) tick();
        chk("R5 still busy before completion", status, 8'h03);
        tick();
        chk("R1 layout after write", status, 8'h9C);
        chk("R11 latch cleared by write", status[1], 1'b0);

        wp_n = 0;
        wren();
        wrr(8'h00);
        chk("R4 protected write dropped", wrr_ok, 1'b0);
        chk("R4 protected contents", status, 8'h9E);
        wp_n = 1;
        wrr(8'h02);
        chk("R4 pin high accepts", wrr_ok, 1'b1);
        wait_write();
        chk("R2 data byte leaves latch", status, 8'h00);

        wrdi();
        wrr(8'h9C);
        chk("R3 write without latch", wrr_ok, 1'b0);
        chk("R3 contents unchanged", status, 8'h00);

        start(2'd0);
        chk("R6 program without latch", status, 8'h00);
        wren();
        start(2'd3);
        chk("R6 other op accepted", status, 8'h03);
        done(0, 0);
        chk("R11 other op keeps latch", status, 8'h02);
        start(2'd0);
        wrdi();
        chk("R10 clear ignored while busy", status, 8'h03);
        wrr(8'hFF);
        chk("R10 write ignored while busy", wrr_ok, 1'b0);
        done(1, 0);
        chk("R7 program fail", status, 8'h40);

        wren();
        start(2'd1);
        done(0, 1);
        chk("R8 sector erase protected", status, 8'h60);
        clsr();
        chk("R9 clear errors", status, 8'h00);
        wren();
        start(2'd2);
        done(0, 1);
        chk("R8 bulk erase protected no error", status, 8'h00);
        wren();
        start(2'd2);
        done(1, 0);
        chk("R8 bulk erase fail", status, 8'h20);
        wren();
        start(2'd0);
        done(0, 1);
        chk("R7 program protected", status, 8'h60);
        wren();
        start(2'd1);
        clsr();
        chk("R9 clear while busy", status, 8'h03);
        done(0, 0);
        start(2'd0);
        chk("R6 ignored after latch clear", status, 8'h00);

        wren();
        start(2'd0);
        done(1, 0);
        wren();
        wrr(8'h7C);
        wait_write();
        chk("R9 write leaves error bits", status, 8'h5C);

        pulse_rst(0);
        chk("R12 reset keeps protect", status, 8'h1C);
        wren();
        wrr(8'h80);
        wait_write();
        chk("R4 lock set", status, 8'h80);
        pulse_rst(1);
        chk("R12 volatile protect ones", status, 8'h9C);
        por_load = 1; tick(); por_load = 0;
        chk("R13 power-on clears lock", status, 8'h00);

        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 20);
            if ($urandom % 8 == 0) wp_n = $urandom % 2;
            op_fail = $urandom % 2;
            op_prot = $urandom % 2;
            case (r)
                0, 1, 2: cmd_wren = 1;
                3:       cmd_wrdi = 1;
                4:       cmd_clsr = 1;
                5:       cmd_rdsr = 1;
                6, 7, 8: begin cmd_wrr = 1; wrr_data = 8'($urandom); end
                9, 10:   begin op_start = 1; op_kind = 2'($urandom); end
                11, 12:  op_done = 1;
                13:      if ($urandom % 40 == 0) begin
                             rst_n = 0; cfg_bp_volatile = $urandom % 2;
                         end
                default: ;
            endcase
            tick();
            rst_n = 1;
        end

        if (!finished) begin
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            finished = 1;
            $finish;
        end
    end
endmodule